// File: doc/BRIEF.md
# Board Interrupt Level Aggregator

This block gathers thirteen level-sensitive interrupt lines from board peripherals and collapses them into a single 4-bit encoded interrupt level for the processor. Nine lines come from fixed on-board devices. Four come from expansion slots, where slot number n is wired to the n-th shared PCI interrupt line. Each source owns one bit of a 16-bit raw-status vector and carries a fixed priority level. The raw status follows the input pins directly and is never latched.

Software enables sources through a mask register. Among the sources that are both pending and enabled, the one with the numerically smallest level wins. That level is inverted (XOR 15) and registered onto the output. When no source qualifies, the output is zero.

A small 64-byte register window sits on a simple synchronous bus. It holds the mask, a power-off trigger that emits a one-cycle shutdown request, a read-only version word, and a general-purpose output port.

Top module: `irlAggTop`

## Requirements
- R1: After reset the mask reads zero, the output port is zero, `irlOut` is 0, `shutdownReq` is 0 and `busRdata` is 0.
- R2: A source takes part in arbitration only while its raw-status bit and its mask bit are both 1. A pending source whose mask bit is 0 leaves `irlOut` at 0.
- R3: Sources are paired with a status/mask bit and a level as follows.
  - bit 0: external, level 11
  - bit 4: RTC tick, level 7
  - bit 5: RTC alarm, level 6
  - bit 6: key, level 5
  - bit 7: SD card, level 8
  - bit 8: CF detect, level 2
  - bit 9: CF IDE, level 1
  - bit 10: graphics, level 4
  - bit 11: slot 3, level 0
  - bit 12: slot 2, level 3
  - bit 13: slot 1, level 10
  - bit 14: slot 0, level 9
  - bit 15: touch panel, level 12

  The taking-part source with the smallest level wins.
- R4: `irlOut` equals the winning level XOR 15. With no taking-part source it is 0.
- R5: `irlOut` is registered. It reflects inputs and mask as sampled at the previous rising clock edge, so an input change does not alter it before that edge.
- R6: `boardIrq` bit order is 0 CF IDE, 1 CF detect, 2 graphics, 3 key, 4 RTC alarm, 5 RTC tick, 6 SD card, 7 external, 8 touch panel. `pciSlotIrq[n]` is slot n. Slots 0, 1, 2 and 3 carry the A, B, C and D interrupt lines.
- R7: A write at offset 0x00 loads the 16-bit mask. A read at 0x00 returns the last value written.
- R8: A write at offset 0x30 raises `shutdownReq` for exactly the one cycle after the write edge. A read at 0x30 returns zero.
- R9: A read at offset 0x32 returns the parameter `VERSION_ID`. Writes to 0x32 have no effect.
- R10: A write at offset 0x36 loads the output port, which drives `portOut`. A read at 0x36 returns it.
- R11: Reads of any other offset return zero. Writes to other offsets change neither mask nor port.
- R12: Raw status is not latched. When a pending input returns low, its source stops taking part at the next edge.
- R13: Read data is registered. `busRdata` updates at the edge that samples `busSel=1, busWe=0` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boardIrq | input | 9 | On-board device interrupt levels (order per R6) |
| pciSlotIrq | input | 4 | Slot interrupt levels, index = slot number |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset in the register window |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| irlOut | output | 4 | Inverted winning level, 0 = no interrupt |
| shutdownReq | output | 1 | One-cycle power-off request |
| portOut | output | 16 | General-purpose output port value |

## Verification
The bench keeps the default widths and overrides `VERSION_ID` with a non-trivial pattern, so the version readback cannot pass by accident on a zero or all-ones value. Random input and mask patterns are mixed with directed cases that walk every source alone to prove each bit/level pairing. Further cases pit the two best-priority sources against the rest, masking away the winner, and dropping a pending line. The window edges (power-off pulse, version write, unmapped offsets) get directed accesses.

// File: rtl/irlAggPkg.sv
package irlAggPkg;

  localparam int BOARD_SRC_N = 9;
  localparam int SLOT_SRC_N  = 4;
  localparam int SRC_TOTAL   = BOARD_SRC_N + SLOT_SRC_N;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_MASK = 2'd1,
    RD_VER  = 2'd2,
    RD_PORT = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   maskWr;
    logic   portWr;
    logic   offWr;
    logic   rdEn;
    rdSel_e rdSel;
  } busStrobe_t;

  // Source index: 0..8 on-board devices, 9..12 slots 0..3
  function automatic int srcBitPos(input int idx);
    case (idx)
      0:  return 9;
      1:  return 8;
      2:  return 10;
      3:  return 6;
      4:  return 5;
      5:  return 4;
      6:  return 7;
      7:  return 0;
      8:  return 15;
      9:  return 14;
      10: return 13;
      11: return 12;
      12: return 11;
      default: return 1;
    endcase
  endfunction

  function automatic int srcPrio(input int idx);
    case (idx)
      0:  return 1;
      1:  return 2;
      2:  return 4;
      3:  return 5;
      4:  return 6;
      5:  return 7;
      6:  return 8;
      7:  return 11;
      8:  return 12;
      9:  return 9;
      10: return 10;
      11: return 3;
      12: return 0;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/irlAggControl.sv
module irlAggControl
  import irlAggPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe,
  output logic              shutdownReq
);

  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_POWER = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFF_VER   = ADDR_W'(8'h32);
  localparam logic [ADDR_W-1:0] OFF_PORT  = ADDR_W'(8'h36);

  logic wrAcc;
  logic rdAcc;
  logic offPulse;

  assign wrAcc = busSel && busWe;
  assign rdAcc = busSel && !busWe;

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_ZERO;
    strobe.rdEn   = rdAcc;
    strobe.maskWr = wrAcc && (busAddr == OFF_MASK);
    strobe.portWr = wrAcc && (busAddr == OFF_PORT);
    strobe.offWr  = wrAcc && (busAddr == OFF_POWER);
    unique case (busAddr)
      OFF_MASK: strobe.rdSel = RD_MASK;
      OFF_VER:  strobe.rdSel = RD_VER;
      OFF_PORT: strobe.rdSel = RD_PORT;
      default:  strobe.rdSel = RD_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) offPulse <= 1'b0;
    else       offPulse <= strobe.offWr;
  end

  assign shutdownReq = offPulse;

  // R8
  shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(busSel && busWe && (busAddr == OFF_POWER)));

  // R11
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.maskWr, strobe.portWr, strobe.offWr}));

endmodule

// File: rtl/irlAggDatapath.sv
module irlAggDatapath
  import irlAggPkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          LEVEL_W    = 4,
  parameter int          SRC_N      = 13,
  parameter logic [15:0] VERSION_ID = 16'h0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_N-1:0]   srcIn,
  input  logic [DATA_W-1:0]  wrData,
  input  busStrobe_t         strobe,
  output logic [DATA_W-1:0]  rdData,
  output logic [LEVEL_W-1:0] irlOut,
  output logic [DATA_W-1:0]  portOut
);

  localparam logic [LEVEL_W-1:0] IDLE_LEVEL = {LEVEL_W{1'b1}};

  logic [DATA_W-1:0]  statusVec;
  logic [DATA_W-1:0]  maskReg;
  logic [DATA_W-1:0]  portReg;
  logic [DATA_W-1:0]  actVec;
  logic [LEVEL_W-1:0] candLvl [SRC_N];
  logic [LEVEL_W-1:0] bestLvl;
  logic [LEVEL_W-1:0] irlReg;

  // Raw status follows the pins; unused bit positions stay zero
  always_comb begin
    statusVec = '0;
    for (int i = 0; i < SRC_N; i++) begin
      statusVec[srcBitPos(i)] = srcIn[i];
    end
  end

  assign actVec = statusVec & maskReg;

  for (genvar g = 0; g < SRC_N; g++) begin : g_cand
    localparam int BIT_POS = srcBitPos(g);
    localparam logic [LEVEL_W-1:0] PRIO = LEVEL_W'(srcPrio(g));
    assign candLvl[g] = actVec[BIT_POS] ? PRIO : IDLE_LEVEL;
  end

  always_comb begin
    bestLvl = IDLE_LEVEL;
    for (int i = 0; i < SRC_N; i++) begin
      if (candLvl[i] < bestLvl) bestLvl = candLvl[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      portReg <= '0;
      irlReg  <= '0;
    end else begin
      if (strobe.maskWr) maskReg <= wrData;
      if (strobe.portWr) portReg <= wrData;
      irlReg <= bestLvl ^ IDLE_LEVEL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        RD_MASK: rdData <= maskReg;
        RD_VER:  rdData <= DATA_W'(VERSION_ID);
        RD_PORT: rdData <= portReg;
        default: rdData <= '0;
      endcase
    end
  end

  assign irlOut  = irlReg;
  assign portOut = portReg;

  // R4
  idle_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(actVec) == '0) |-> (irlOut == '0));

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskReg) == '0) |-> (irlOut == '0));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.maskWr) |-> (maskReg == $past(maskReg)));

  // R10
  port_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.portWr) |-> $stable(portReg));

endmodule

// File: rtl/irlAggTop.sv
module irlAggTop
  import irlAggPkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          DATA_W     = 16,
  parameter int          LEVEL_W    = 4,
  parameter logic [15:0] VERSION_ID = 16'h0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [8:0]         boardIrq,
  input  logic [3:0]         pciSlotIrq,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [LEVEL_W-1:0] irlOut,
  output logic               shutdownReq,
  output logic [DATA_W-1:0]  portOut
);

  localparam int SRC_N = BOARD_SRC_N + SLOT_SRC_N;

  busStrobe_t       strobe;
  logic [SRC_N-1:0] srcIn;

  assign srcIn = {pciSlotIrq, boardIrq};

  irlAggControl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .strobe     (strobe),
    .shutdownReq(shutdownReq)
  );

  irlAggDatapath #(
    .DATA_W    (DATA_W),
    .LEVEL_W   (LEVEL_W),
    .SRC_N     (SRC_N),
    .VERSION_ID(VERSION_ID)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .wrData (busWdata),
    .strobe (strobe),
    .rdData (busRdata),
    .irlOut (irlOut),
    .portOut(portOut)
  );

endmodule

// File: tb/irlAggTop_tb.sv
`timescale 1ns/1ps
module irlAggTop_tb;

  localparam logic [15:0] VER = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  boardIrq = '0;
  logic [3:0]  pciSlotIrq = '0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [3:0]  irlOut;
  logic        shutdownReq;
  logic [15:0] portOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irlAggTop #(.VERSION_ID(VER)) u_dut (
    .clk(clk), .rstN(rstN), .boardIrq(boardIrq), .pciSlotIrq(pciSlotIrq),
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irlOut(irlOut), .shutdownReq(shutdownReq),
    .portOut(portOut)
  );

  // Expected values from the requirement tables (R3, R6)
  function automatic logic [3:0] expIrl(logic [8:0] b, logic [3:0] p, logic [15:0] m);
    int bitOf [13] = '{9, 8, 10, 6, 5, 4, 7, 0, 15, 14, 13, 12, 11};
    int lvlOf [13] = '{1, 2, 4, 5, 6, 7, 8, 11, 12, 9, 10, 3, 0};
    logic [12:0] src;
    int best;
    src = {p, b};
    best = 15;
    for (int i = 0; i < 13; i++)
      if (src[i] && m[bitOf[i]] && lvlOf[i] < best) best = lvlOf[i];
    return 4'(best) ^ 4'hF;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic setIrq(logic [8:0] b, logic [3:0] p);
    @(negedge clk);
    boardIrq = b; pciSlotIrq = p;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    logic [15:0] mask;
    logic [3:0]  prev;
    int unsigned seed;
    seed = $urandom(32'd7321);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irl", 16'(irlOut), 16'h0);
    chk("R1 shutdown", 16'(shutdownReq), 16'h0);
    chk("R1 port", portOut, 16'h0);
    chk("R1 rdata", busRdata, 16'h0);
    rstN = 1'b1;
    busRead(6'h00, rd);
    chk("R1 mask reset", rd, 16'h0);

    // R2 pending but masked
    setIrq(9'h1FF, 4'hF);
    chk("R2 all pending, mask zero", 16'(irlOut), 16'h0);

    // R7 mask readback
    busWrite(6'h00, 16'hFFFF);
    mask = 16'hFFFF;
    busRead(6'h00, rd);
    chk("R7 mask readback", rd, 16'hFFFF);
    chk("R3 best is slot3 level 0", 16'(irlOut), 16'hF);

    // R3/R6 each source alone
    for (int i = 0; i < 13; i++) begin
      logic [12:0] one;
      one = 13'(1) << i;
      setIrq(one[8:0], one[12:9]);
      chk($sformatf("R3 R6 single source %0d", i), 16'(irlOut),
          16'(expIrl(one[8:0], one[12:9], mask)));
    end

    // R2 masking the winner exposes next
    setIrq(9'h003, 4'h8);
    busWrite(6'h00, 16'hF7FF);
    mask = 16'hF7FF;
    @(negedge clk);
    chk("R2 winner masked", 16'(irlOut), 16'(4'd1 ^ 4'hF));

    // R12 not latched
    setIrq(9'h002, 4'h0);
    chk("R12 line dropped", 16'(irlOut), 16'(4'd2 ^ 4'hF));
    setIrq(9'h000, 4'h0);
    chk("R4 none pending gives zero", 16'(irlOut), 16'h0);

    // R5 latency: output holds until the next edge
    prev = irlOut;
    @(negedge clk);
    boardIrq = 9'h001;
    #1;
    chk("R5 no change before edge", 16'(irlOut), 16'(prev));
    @(negedge clk);
    chk("R5 change after edge", 16'(irlOut), 16'(4'd1 ^ 4'hF));

    // R8 power-off pulse
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = 6'h30; busWdata = 16'h1;
    #1;
    chk("R8 not before edge", 16'(shutdownReq), 16'h0);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
    chk("R8 pulse high", 16'(shutdownReq), 16'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", 16'(shutdownReq), 16'h0);
    busRead(6'h30, rd);
    chk("R8 read zero", rd, 16'h0);

    // R9 version
    busWrite(6'h32, 16'h1234);
    busRead(6'h32, rd);
    chk("R9 version", rd, VER);

    // R10 port
    busWrite(6'h36, 16'hBEEF);
    chk("R10 portOut", portOut, 16'hBEEF);
    busRead(6'h36, rd);
    chk("R10 port readback", rd, 16'hBEEF);

    // R11 unmapped
    busWrite(6'h02, 16'h5555);
    busWrite(6'h3E, 16'h5555);
    busRead(6'h04, rd);
    chk("R11 unmapped read", rd, 16'h0);
    busRead(6'h00, rd);
    chk("R11 mask untouched", rd, mask);
    chk("R11 port untouched", portOut, 16'hBEEF);

    // R13 read data holds without a read
    repeat (3) @(negedge clk);
    chk("R13 rdata holds", busRdata, mask);

    // Random patterns
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        mask = 16'($urandom());
        busWrite(6'h00, mask);
      end
      setIrq(9'($urandom()), 4'($urandom()));
      chk("R3 R4 random", 16'(irlOut), 16'(expIrl(boardIrq, pciSlotIrq, mask)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule